// File: doc/BRIEF.md
# Select-Edge Latched Read-Only Memory

This block is a clocked model of an 8192-word by 8-bit read-only memory. Each read cycle opens on the falling edge of an active-low select input. On that edge the block takes the address and fetches the addressed word into an internal data register. After that the address pins are free to change. A separate active-low drive input controls only whether the word is presented. The drive input is never captured by the select edge. A `dout_en` flag stands in for three-state output buffers.

Every analog delay is counted in clock cycles and set by a parameter: select access, drive access, data-off, precharge and power-up settling. The block watches for cycles that open too early. One opens too early when select falls before the line has rested high for the precharge interval, or before the power-up interval has passed since reset. Either case sets a sticky violation flag, and that cycle never presents data. The contents are fixed at elaboration by a parameterised mixing function of the address.

Top module: `latched_addr_rom`

## Requirements
- R1: The word stored at address `a` is `a[7:0] ^ {a[12:8], 3'b000} ^ SEED`, with `SEED` defaulting to 8'hA5. A cycle fetches the word addressed at the first clock edge at which `sel_n` is sampled low after being sampled high.
- R2: Changing `addr` at any edge after the capturing edge has no effect on the word presented during that cycle.
- R3: When the drive condition has already been met, `dout_en` rises exactly `T_SEL` clock edges after the capturing edge, and no earlier.
- R4: `dout_en` rises exactly `T_DRV` edges after the first edge at which `drv_n` is sampled low during an open cycle, if that edge comes later than the select condition. `dout_en` never rises unless both `sel_n` and `drv_n` were low at the enabling edge.
- R5: `drv_n` is not latched. During an open cycle, raising `drv_n` and lowering it again re-presents the same word after `T_DRV` edges, with no new select edge. With `sel_n` high, a low `drv_n` alone never asserts `dout_en`.
- R6: After `sel_n` or `drv_n` is first sampled high, the word stays driven and unchanged for `T_OFF` more edges. `dout_en` then falls on the following edge.
- R7: `dout` reads zero whenever `dout_en` is low.
- R8: A select edge preceded by fewer than `T_PRE` consecutive high samples of `sel_n` sets `viol`, and that cycle never asserts `dout_en`. Exactly `T_PRE` high samples is a valid cycle.
- R9: Until `sel_n` has first been sampled high on `T_START` consecutive edges after reset, a select edge sets `viol` and presents no data. `T_START` edges is enough.
- R10: During and right after reset, `dout_en`, `dout` and `viol` are all zero.
- R11: Once set, `viol` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low select; its falling edge opens a cycle and captures the address |
| drv_n | input | 1 | Active-low output drive request, not latched |
| addr | input | 13 | Word address |
| dout | output | 8 | Read data, zero while not driven |
| dout_en | output | 1 | High while the data bus would be actively driven |
| viol | output | 1 | Sticky flag for a precharge or power-up timing violation |

## Verification
Two timers can expire on the same clock edge: the select access count and the drive access count. The bench provokes this by lowering `drv_n` exactly `T_SEL - T_DRV` edges after the select edge. It then demands that `dout_en` is still low one edge before the shared expiry and high with the correct word on it. The other coincidence is a select edge that lands exactly on the edge where precharge, or power-up, is satisfied. The bench runs every sweep read at that exact boundary and requires `viol` to stay clear. It also runs the case one edge shorter and requires `viol` to set and no data to appear.

// File: rtl/rom_if_pkg.sv
package rom_if_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_GOOD = 2'd1,
    CYC_BAD  = 2'd2
  } cyc_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rom_run_counter.sv
module rom_run_counter #(
  parameter int LIMIT = 4,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [CW-1:0] cnt
);

  // Counts consecutive edges with run high, saturating at LIMIT.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt != CW'(LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rom_cycle_ctl.sv
module rom_cycle_ctl
  import rom_if_pkg::*;
#(
  parameter int T_PRE   = 3,
  parameter int T_START = 16,
  parameter int PW      = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_n,
  input  logic [PW-1:0] pre_cnt,
  output logic          sel_fall,
  output logic          cyc_good,
  output logic          viol
);

  logic       sel_d1;
  logic       start_done;
  logic       fall_ok;
  cyc_state_t state;

  assign sel_fall = sel_d1 & ~sel_n;
  assign fall_ok  = (pre_cnt >= PW'(T_PRE)) &&
                    (start_done || (pre_cnt >= PW'(T_START)));
  assign cyc_good = (state == CYC_GOOD);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_d1     <= 1'b1;
      start_done <= 1'b0;
      state      <= CYC_IDLE;
      viol       <= 1'b0;
    end else begin
      sel_d1 <= sel_n;
      if (pre_cnt >= PW'(T_START)) begin
        start_done <= 1'b1;
      end
      if (sel_n) begin
        state <= CYC_IDLE;
      end else if (sel_fall) begin
        state <= fall_ok ? CYC_GOOD : CYC_BAD;
      end
      if (sel_fall && !fall_ok) begin
        viol <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rom_word_store.sv
module rom_word_store #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] SEED = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data
);

  // Contents fixed at elaboration: low bits of the address, upper bits
  // shifted up by three, and the seed, all folded by XOR.
  function automatic logic [DATA_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W+DATA_W-1:0] wide;
    wide    = {{DATA_W{1'b0}}, a};
    word_of = wide[DATA_W-1:0] ^ DATA_W'((wide >> DATA_W) << 3) ^ SEED;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (capture) begin
      rd_data <= word_of(addr);
    end
  end

endmodule

// File: rtl/latched_addr_rom.sv
module latched_addr_rom
  import rom_if_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter logic [DATA_W-1:0] SEED = 8'hA5,
  parameter int T_SEL   = 3,
  parameter int T_DRV   = 2,
  parameter int T_OFF   = 1,
  parameter int T_PRE   = 3,
  parameter int T_START = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              drv_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              viol
);

  localparam int PRE_MAX = max_of(T_PRE, T_START);
  localparam int PW      = $clog2(PRE_MAX + 1);
  localparam int SW      = $clog2(T_SEL + 1);
  localparam int DW      = $clog2(T_DRV + 1);

  logic [PW-1:0]     pre_cnt;
  logic [SW-1:0]     sel_cnt;
  logic [DW-1:0]     drv_cnt;
  logic              sel_fall;
  logic              cyc_good;
  logic [DATA_W-1:0] rd_data;
  logic              rel_w;
  logic              hold;
  logic              present;

  rom_run_counter #(.LIMIT(PRE_MAX)) u_pre_cnt (
    .clk (clk), .rst (rst), .run (sel_n), .cnt (pre_cnt)
  );

  rom_run_counter #(.LIMIT(T_SEL)) u_sel_cnt (
    .clk (clk), .rst (rst), .run (~sel_n), .cnt (sel_cnt)
  );

  rom_run_counter #(.LIMIT(T_DRV)) u_drv_cnt (
    .clk (clk), .rst (rst), .run (~drv_n), .cnt (drv_cnt)
  );

  rom_cycle_ctl #(.T_PRE(T_PRE), .T_START(T_START), .PW(PW)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (sel_n),
    .pre_cnt  (pre_cnt),
    .sel_fall (sel_fall),
    .cyc_good (cyc_good),
    .viol     (viol)
  );

  rom_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED)) u_store (
    .clk     (clk),
    .rst     (rst),
    .capture (sel_fall),
    .addr    (addr),
    .rd_data (rd_data)
  );

  assign rel_w   = sel_n | drv_n;
  assign present = cyc_good && !sel_n && !drv_n &&
                   (sel_cnt >= SW'(T_SEL)) && (drv_cnt >= DW'(T_DRV));

  generate
    if (T_OFF == 0) begin : g_no_off
      assign hold = 1'b0;
    end else begin : g_off
      localparam int RW = $clog2(T_OFF + 1);
      logic [RW-1:0] rel_cnt;
      rom_run_counter #(.LIMIT(T_OFF)) u_rel_cnt (
        .clk (clk), .rst (rst), .run (rel_w & dout_en), .cnt (rel_cnt)
      );
      assign hold = dout_en && rel_w && (rel_cnt < RW'(T_OFF));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_en <= 1'b0;
      dout    <= '0;
    end else begin
      dout_en <= present | hold;
      if (present) begin
        dout <= rd_data;
      end else if (!hold) begin
        dout <= '0;
      end
    end
  end

endmodule

// File: rtl/latched_addr_rom_chk.sv
module latched_addr_rom_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n,
  input logic              drv_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              viol
);

  // R4
  en_needs_sel_drv_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_en) |-> $past(!sel_n && !drv_n));

  // R7
  off_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> (dout == '0));

  // R6
  driven_word_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_en && $past(dout_en)) |-> $stable(dout));

  // R11
  viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    viol |=> viol);

  // R8
  viol_on_select_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(viol) |-> $past(!sel_n));

endmodule

bind latched_addr_rom latched_addr_rom_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sel_n   (sel_n),
  .drv_n   (drv_n),
  .dout    (dout),
  .dout_en (dout_en),
  .viol    (viol)
);

// File: tb/tb_latched_addr_rom.sv
`timescale 1ns/1ps
module tb_latched_addr_rom;

  localparam int T_SEL   = 3;
  localparam int T_DRV   = 2;
  localparam int T_OFF   = 1;
  localparam int T_PRE   = 3;
  localparam int T_START = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        sel_n;
  logic        drv_n;
  logic [12:0] addr;
  logic [7:0]  dout;
  logic        dout_en;
  logic        viol;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  latched_addr_rom #(
    .ADDR_W(13), .DATA_W(8), .SEED(8'hA5),
    .T_SEL(T_SEL), .T_DRV(T_DRV), .T_OFF(T_OFF),
    .T_PRE(T_PRE), .T_START(T_START)
  ) dut (
    .clk (clk), .rst (rst), .sel_n (sel_n), .drv_n (drv_n),
    .addr (addr), .dout (dout), .dout_en (dout_en), .viol (viol)
  );

  function automatic logic [7:0] exp_word(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b000} ^ 8'hA5;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; sel_n = 1'b1; drv_n = 1'b1; addr = '0;
    repeat (3) tick();
    chk(dout_en == 1'b0, "R10 dout_en", dout_en, 0);
    chk(dout == 8'h00, "R10 dout", dout, 0);
    chk(viol == 1'b0, "R10 viol", viol, 0);
    rst = 1'b0;
  endtask

  // One read with drv_n held low; leaves sel_n high for npre edges.
  task automatic rd(input logic [12:0] a, input int npre);
    logic [7:0] e;
    e = exp_word(a);
    addr = a; sel_n = 1'b0;
    tick();
    addr = ~a;
    repeat (T_SEL - 1) tick();
    chk(dout_en == 1'b0, "R3 early", dout_en, 0);
    tick();
    chk(dout_en == 1'b1, "R3 on time", dout_en, 1);
    chk(dout == e, "R1/R2 word", dout, e);
    sel_n = 1'b1; addr = a ^ 13'h0155;
    repeat (T_OFF) tick();
    chk(dout_en == 1'b1 && dout == e, "R6 hold", dout, e);
    tick();
    chk(dout_en == 1'b0, "R6 off", dout_en, 0);
    chk(dout == 8'h00, "R7 zero", dout, 0);
    repeat (npre - T_OFF - 1) tick();
    chk(dout_en == 1'b0, "R5 drive alone", dout_en, 0);
  endtask

  task automatic drv_case(input logic [12:0] a);
    logic [7:0] e;
    e = exp_word(a);
    drv_n = 1'b1; addr = a; sel_n = 1'b0;
    tick();
    repeat (T_SEL + 1) tick();
    chk(dout_en == 1'b0, "R4 no drive", dout_en, 0);
    drv_n = 1'b0;
    repeat (T_DRV) tick();
    chk(dout_en == 1'b0, "R4 early", dout_en, 0);
    tick();
    chk(dout_en == 1'b1 && dout == e, "R4 on time", dout, e);
    drv_n = 1'b1; addr = ~a;
    repeat (T_OFF) tick();
    chk(dout_en == 1'b1, "R6 drv hold", dout_en, 1);
    tick();
    chk(dout_en == 1'b0, "R6 drv off", dout_en, 0);
    drv_n = 1'b0;
    repeat (T_DRV) tick();
    chk(dout_en == 1'b0, "R5 re-drive early", dout_en, 0);
    tick();
    chk(dout_en == 1'b1 && dout == e, "R5 re-drive word", dout, e);
    sel_n = 1'b1;
    repeat (T_PRE) tick();
    chk(dout_en == 1'b0, "R6 release", dout_en, 0);
  endtask

  // Drive access and select access expire on the same edge.
  task automatic coincide(input logic [12:0] a);
    logic [7:0] e;
    e = exp_word(a);
    drv_n = 1'b1; addr = a; sel_n = 1'b0;
    tick();
    repeat (T_SEL - T_DRV - 1) tick();
    drv_n = 1'b0;
    repeat (T_DRV) tick();
    chk(dout_en == 1'b0, "R3/R4 shared early", dout_en, 0);
    tick();
    chk(dout_en == 1'b1 && dout == e, "R3/R4 shared expiry", dout, e);
    sel_n = 1'b1;
    repeat (T_PRE) tick();
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R9: one edge short of the power-up interval
    repeat (T_START - 1) tick();
    sel_n = 1'b0; drv_n = 1'b0; addr = 13'd5;
    tick();
    chk(viol == 1'b1, "R9 early select", viol, 1);
    repeat (T_SEL + 2) tick();
    chk(dout_en == 1'b0, "R9 no data", dout_en, 0);

    do_reset();
    drv_n = 1'b0;
    repeat (T_START) tick();
    rd(13'h0000, T_PRE);
    chk(viol == 1'b0, "R9 boundary ok", viol, 0);
    for (int a = 7; a < 8192; a += 7) rd(13'(a), T_PRE);
    rd(13'h1FFF, T_PRE);
    chk(viol == 1'b0, "R8 boundary ok", viol, 0);
    drv_case(13'h0ABC);
    drv_case(13'h1F00);
    coincide(13'h1234);
    coincide(13'h00FF);
    drv_n = 1'b0;
    rd(13'h0777, T_PRE - 1);
    sel_n = 1'b0; addr = 13'h0100;
    tick();
    chk(viol == 1'b1, "R8 short precharge", viol, 1);
    repeat (T_SEL + 2) tick();
    chk(dout_en == 1'b0, "R8 no data", dout_en, 0);
    sel_n = 1'b1;
    repeat (10) tick();
    chk(viol == 1'b1, "R11 sticky", viol, 1);
    do_reset();
    tick();
    chk(viol == 1'b0, "R10 viol cleared", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule